// File: doc/BRIEF.md
# Multiplier Contention Pipeline Interlock

This block is the hazard and stall controller for a five-stage in-order integer pipeline (fetch, decode, execute, memory access, write-back) whose multiply unit is shared and takes several cycles. Each cycle the fetch side offers one decoded instruction. The offer carries a class code and a small tag. The block moves instructions through the decode, execute, memory and write-back slots. It reports when decode or execute is held, whether the multiplier is occupied, and which tag sits in each slot, so a checker can follow the pipeline.

Two classes load the multiplier. A long multiply-accumulate from memory takes two consecutive memory-access cycles and leaves the multiplier busy for a tail of `MACL_TAIL` cycles, 4 by default. The instruction right behind it always loses exactly one decode slot. A word multiply-accumulate takes one memory-access cycle and a tail of `MACW_TAIL` cycles, 2 by default. Any later instruction that needs the multiplier waits in execute until the tail has run out. Instructions that do not use the multiplier are never held by the tail. A stall always leaves an empty slot downstream; it never duplicates an instruction.

Top module: `mulc_interlock`

## Requirements
- R1: A synchronous active-high `rst` empties every slot, clears the busy tail and both stall outputs, and leaves `if_ready` high.
- R2: Class codes on `if_cls` are 0 = plain, 1 = long multiply-accumulate, 2 = word multiply-accumulate, 3 = other multiply, 4 = multiply-register transfer, and 5 to 7 = plain. Codes 1 to 4 use the multiplier. A plain instruction with no hazard shows its tag in decode, execute, memory and write-back on four consecutive cycles.
- R3: A long multiply-accumulate occupies the memory slot for two consecutive cycles. `tr_ma_second` is high only in the second of them.
- R4: When a long multiply-accumulate leaves execute, the instruction in decode stays there one extra cycle (`id_stall` high) and execute is empty in the next cycle.
- R5: After the second memory cycle of a long multiply-accumulate, `mul_busy` is high for exactly `MACL_TAIL` cycles.
- R6: A word multiply-accumulate takes one memory cycle, after which `mul_busy` is high for exactly `MACW_TAIL` cycles.
- R7: An instruction of codes 1 to 4 in execute is held there (`ex_stall` high) while `mul_busy` is high or a multiply-accumulate is in its last memory cycle. It enters memory in the cycle after the first cycle in which neither holds.
- R8: Plain instructions are never held by the multiplier tail. They move from execute to memory whenever the memory slot is free.
- R9: Multiply-accumulate instructions leave the pipeline after their last memory cycle and never appear in write-back. All other classes do appear in write-back.
- R10: When execute is held, the memory slot is empty in the next cycle unless a long multiply-accumulate moves into its second memory cycle. When decode is held, execute is empty in the next cycle unless it is held too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| if_valid | input | 1 | Fetch offers an instruction |
| if_cls | input | 3 | Class code of the offered instruction |
| if_tag | input | TAG_W | Identifier of the offered instruction |
| if_ready | output | 1 | Decode takes the offered instruction at the next edge |
| id_stall | output | 1 | Decode instruction is held this cycle |
| ex_stall | output | 1 | Execute instruction is held this cycle |
| mul_busy | output | 1 | Multiplier tail is running |
| tr_id_v | output | 1 | Decode slot occupied |
| tr_id_tag | output | TAG_W | Decode slot tag |
| tr_ex_v | output | 1 | Execute slot occupied |
| tr_ex_tag | output | TAG_W | Execute slot tag |
| tr_ma_v | output | 1 | Memory slot occupied |
| tr_ma_tag | output | TAG_W | Memory slot tag |
| tr_ma_second | output | 1 | Memory slot holds the second cycle of a long multiply-accumulate |
| tr_wb_v | output | 1 | Write-back slot occupied |
| tr_wb_tag | output | TAG_W | Write-back slot tag |

## Verification
The bench runs instruction streams through the block and checks slot occupancy, stalls and the busy flag on every cycle against a per-instruction timing model. A run of plain instructions checks that flow without hazards is unimpeded. A long multiply-accumulate followed by plain work separates the one-slot decode loss from any tail wait. Back-to-back multiply-accumulates, and a word multiply-accumulate followed by a multiply and a transfer, show whether the tail hold releases on exactly the right cycle. A long mixed stream, with plain work slipping past a running tail, shows that only multiplier users wait and that bubbles appear in the right places. A reset during a running tail shows that the busy state really clears.

// File: rtl/mulc_interlock.sv
module mulc_interlock #(
  parameter int TAG_W     = 4,
  parameter int MACL_TAIL = 4,
  parameter int MACW_TAIL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             if_valid,
  input  logic [2:0]       if_cls,
  input  logic [TAG_W-1:0] if_tag,
  output logic             if_ready,
  output logic             id_stall,
  output logic             ex_stall,
  output logic             mul_busy,
  output logic             tr_id_v,
  output logic [TAG_W-1:0] tr_id_tag,
  output logic             tr_ex_v,
  output logic [TAG_W-1:0] tr_ex_tag,
  output logic             tr_ma_v,
  output logic [TAG_W-1:0] tr_ma_tag,
  output logic             tr_ma_second,
  output logic             tr_wb_v,
  output logic [TAG_W-1:0] tr_wb_tag
);

  localparam int TAIL_MAX = (MACL_TAIL > MACW_TAIL) ? MACL_TAIL : MACW_TAIL;
  localparam int CNT_W    = $clog2(TAIL_MAX + 1);

  localparam logic [2:0] C_MACL = 3'd1;
  localparam logic [2:0] C_MACW = 3'd2;
  localparam logic [2:0] C_MUL  = 3'd3;
  localparam logic [2:0] C_XFER = 3'd4;

  function automatic logic uses_mul(input logic [2:0] c);
    return (c == C_MACL) || (c == C_MACW) || (c == C_MUL) || (c == C_XFER);
  endfunction

  function automatic logic is_mac(input logic [2:0] c);
    return (c == C_MACL) || (c == C_MACW);
  endfunction

  logic             id_v, ex_v, ma_v, ma_sec, wb_v;
  logic [2:0]       id_c, ex_c, ma_c;
  logic [TAG_W-1:0] id_t, ex_t, ma_t, wb_t;
  logic [CNT_W-1:0] cnt;

  logic ma_first, ma_load, mul_block;
  logic ex_hold, ex_go, id_hold, id_go, take;

  assign ma_first  = ma_v && (ma_c == C_MACL) && !ma_sec;
  assign ma_load   = ma_v && is_mac(ma_c) && !ma_first;
  assign mul_block = (cnt != '0) || ma_load;

  assign ex_hold = ex_v && (ma_first || (uses_mul(ex_c) && mul_block));
  assign ex_go   = ex_v && !ex_hold;
  assign id_hold = id_v && ex_v && (ex_hold || (ex_c == C_MACL));
  assign id_go   = id_v && !id_hold;
  assign take    = if_valid && if_ready;

  assign if_ready = !id_hold;
  assign id_stall = id_hold;
  assign ex_stall = ex_hold;
  assign mul_busy = (cnt != '0);

  assign tr_id_v      = id_v;
  assign tr_id_tag    = id_t;
  assign tr_ex_v      = ex_v;
  assign tr_ex_tag    = ex_t;
  assign tr_ma_v      = ma_v;
  assign tr_ma_tag    = ma_t;
  assign tr_ma_second = ma_v && ma_sec;
  assign tr_wb_v      = wb_v;
  assign tr_wb_tag    = wb_t;

  always_ff @(posedge clk) begin
    if (rst) begin
      id_v   <= 1'b0;
      ex_v   <= 1'b0;
      ma_v   <= 1'b0;
      ma_sec <= 1'b0;
      wb_v   <= 1'b0;
      id_c   <= '0;
      ex_c   <= '0;
      ma_c   <= '0;
      id_t   <= '0;
      ex_t   <= '0;
      ma_t   <= '0;
      wb_t   <= '0;
      cnt    <= '0;
    end else begin
      wb_v <= ma_v && !ma_first && !is_mac(ma_c);
      wb_t <= ma_t;

      if (ma_first) begin
        ma_sec <= 1'b1;
      end else begin
        ma_v   <= ex_go;
        ma_c   <= ex_c;
        ma_t   <= ex_t;
        ma_sec <= 1'b0;
      end

      if (!ex_hold) begin
        ex_v <= id_go;
        ex_c <= id_c;
        ex_t <= id_t;
      end

      if (!id_hold) begin
        id_v <= take;
        id_c <= if_cls;
        id_t <= if_tag;
      end

      if (ma_load)
        cnt <= (ma_c == C_MACL) ? CNT_W'(MACL_TAIL) : CNT_W'(MACW_TAIL);
      else if (cnt != '0)
        cnt <= cnt - CNT_W'(1);
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!id_v && !ex_v && !ma_v && !wb_v && !mul_busy && if_ready));

  p_macl_second_r3: assert property (@(posedge clk) disable iff (rst)
    ma_first |=> (ma_v && ma_sec && $stable(ma_t)));

  p_macl_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (ex_v && (ex_c == C_MACL) && !ex_hold && id_v) |=> (id_v && !ex_v));

  p_busy_origin_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mul_busy) |-> $past(ma_v && is_mac(ma_c)));

  p_user_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (ex_v && uses_mul(ex_c) && mul_busy) |=> (ex_v && $stable(ex_t)));

  p_plain_moves_r8: assert property (@(posedge clk) disable iff (rst)
    (ex_v && !uses_mul(ex_c) && !ma_first) |=> (ma_v && (ma_t == $past(ex_t))));

  p_hold_bubble_r10: assert property (@(posedge clk) disable iff (rst)
    (ex_stall && !ma_first) |=> !ma_v);

endmodule

// File: tb/mulc_interlock_tb.sv
module mulc_interlock_tb;
  localparam int PERIOD = 10;
  localparam logic [2:0] K_PLAIN = 3'd0, K_MACL = 3'd1, K_MACW = 3'd2,
                         K_MUL = 3'd3, K_XFER = 3'd4;
  localparam int TAIL_L = 4, TAIL_W = 2;

  logic clk = 1'b0, rst = 1'b1, if_valid = 1'b0;
  logic [2:0] if_cls = '0;
  logic [3:0] if_tag = '0;
  logic if_ready, id_stall, ex_stall, mul_busy;
  logic tr_id_v, tr_ex_v, tr_ma_v, tr_ma_second, tr_wb_v;
  logic [3:0] tr_id_tag, tr_ex_tag, tr_ma_tag, tr_wb_tag;

  always #(PERIOD/2) clk = ~clk;

  mulc_interlock #(.TAG_W(4), .MACL_TAIL(TAIL_L), .MACW_TAIL(TAIL_W)) u_dut (
    .clk(clk), .rst(rst), .if_valid(if_valid), .if_cls(if_cls), .if_tag(if_tag),
    .if_ready(if_ready), .id_stall(id_stall), .ex_stall(ex_stall), .mul_busy(mul_busy),
    .tr_id_v(tr_id_v), .tr_id_tag(tr_id_tag), .tr_ex_v(tr_ex_v), .tr_ex_tag(tr_ex_tag),
    .tr_ma_v(tr_ma_v), .tr_ma_tag(tr_ma_tag), .tr_ma_second(tr_ma_second),
    .tr_wb_v(tr_wb_v), .tr_wb_tag(tr_wb_tag));

  typedef struct packed {
    logic idv; logic [3:0] idt; logic exv; logic [3:0] ext;
    logic mav; logic [3:0] mat; logic ma2; logic wbv; logic [3:0] wbt;
    logic ids; logic exs; logic busy;
  } snap_t;

  snap_t sb[$];
  int total = 0, bad = 0;
  logic [2:0] sc [16];

  function automatic snap_t observe();
    snap_t s;
    s.idv = tr_id_v; s.idt = tr_id_v ? tr_id_tag : 4'd0;
    s.exv = tr_ex_v; s.ext = tr_ex_v ? tr_ex_tag : 4'd0;
    s.mav = tr_ma_v; s.mat = tr_ma_v ? tr_ma_tag : 4'd0;
    s.ma2 = tr_ma_second;
    s.wbv = tr_wb_v; s.wbt = tr_wb_v ? tr_wb_tag : 4'd0;
    s.ids = id_stall; s.exs = ex_stall; s.busy = mul_busy;
    return s;
  endfunction

  function automatic logic user(input logic [2:0] c);
    return c >= 3'd1 && c <= 3'd4;
  endfunction

  task automatic check_reset(input string what);
    total++;
    if (tr_id_v || tr_ex_v || tr_ma_v || tr_wb_v || id_stall || ex_stall ||
        mul_busy || !if_ready) begin
      bad++;
      $display("FAIL R1 %s: actual slots=%b%b%b%b stalls=%b%b busy=%b ready=%b expected all zero, ready=1",
               what, tr_id_v, tr_ex_v, tr_ma_v, tr_wb_v, id_stall, ex_stall, mul_busy, if_ready);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check_reset("after reset");
    rst = 1'b0;
  endtask

  // Driver: computes per-instruction stage timing from the requirements,
  // queues the expected per-cycle picture, then feeds the stream.
  task automatic run_seq(input string req, input int n);
    int idin[16], exin[16], main[16], len[16], fin[16], tl[16];
    int lastf, lasttl, last;
    logic havemac;
    havemac = 1'b0; lastf = 0; lasttl = 0;
    for (int i = 0; i < n; i++) begin
      len[i] = (sc[i] == K_MACL) ? 2 : 1;
      idin[i] = (i == 0) ? 1 : exin[i-1];
      exin[i] = idin[i] + 1;
      if (i > 0 && sc[i-1] == K_MACL && main[i-1] + 1 > exin[i]) exin[i] = main[i-1] + 1; // R4
      if (i > 0 && main[i-1] > exin[i]) exin[i] = main[i-1];
      main[i] = exin[i] + 1;
      if (i > 0 && main[i-1] + len[i-1] > main[i]) main[i] = main[i-1] + len[i-1];
      if (user(sc[i]) && havemac && lastf + lasttl + 2 > main[i]) main[i] = lastf + lasttl + 2; // R7
      fin[i] = main[i] + len[i] - 1;
      tl[i] = (sc[i] == K_MACL) ? TAIL_L : (sc[i] == K_MACW) ? TAIL_W : 0;
      if (tl[i] != 0) begin havemac = 1'b1; lastf = fin[i]; lasttl = tl[i]; end
    end
    last = fin[n-1] + TAIL_L + 3;
    for (int c = 1; c <= last; c++) begin
      snap_t e;
      e = '0;
      for (int i = 0; i < n; i++) begin
        if (c >= idin[i] && c < exin[i]) begin
          e.idv = 1'b1; e.idt = 4'(i); e.ids = (exin[i] > c + 1);
        end
        if (c >= exin[i] && c < main[i]) begin
          e.exv = 1'b1; e.ext = 4'(i); e.exs = (main[i] > c + 1);
        end
        if (c >= main[i] && c <= fin[i]) begin
          e.mav = 1'b1; e.mat = 4'(i); e.ma2 = (sc[i] == K_MACL) && (c == fin[i]);
        end
        if (tl[i] == 0 && c == fin[i] + 1) begin e.wbv = 1'b1; e.wbt = 4'(i); end // R9
        if (tl[i] != 0 && c > fin[i] && c <= fin[i] + tl[i]) e.busy = 1'b1;
      end
      sb.push_back(e);
    end
    fork
      begin
        int k;
        logic acc;
        k = 0;
        while (k < n) begin
          if_valid = 1'b1; if_cls = sc[k]; if_tag = 4'(k);
          acc = if_ready;
          @(posedge clk); @(negedge clk);
          if (acc) k++;
        end
        if_valid = 1'b0;
      end
      begin
        for (int c = 1; c <= last; c++) begin
          snap_t a, e;
          @(posedge clk); @(negedge clk);
          a = observe();
          e = sb.pop_front();
          total++;
          if (a != e) begin
            bad++;
            $display("FAIL %s cycle %0d: actual=%h expected=%h", req, c, a, e);
          end
        end
      end
    join
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2: plain flow, including an unused code treated as plain
    sc[0] = K_PLAIN; sc[1] = K_PLAIN; sc[2] = 3'd6; sc[3] = K_PLAIN;
    run_seq("R2", 4);

    do_reset();
    sc[0] = K_MACL; sc[1] = K_PLAIN; sc[2] = K_PLAIN;
    run_seq("R3,R4", 3);

    do_reset();
    sc[0] = K_MACL; sc[1] = K_MACL; sc[2] = K_PLAIN;
    run_seq("R5,R7", 3);

    do_reset();
    sc[0] = K_MACW; sc[1] = K_MUL; sc[2] = K_XFER;
    run_seq("R6,R7,R9", 3);

    do_reset();
    sc[0] = K_MACL; sc[1] = K_PLAIN; sc[2] = K_PLAIN; sc[3] = K_PLAIN; sc[4] = K_XFER;
    run_seq("R8", 5);

    do_reset();
    sc[0] = K_MACW; sc[1] = K_PLAIN; sc[2] = K_MUL; sc[3] = K_MACL; sc[4] = K_XFER;
    sc[5] = K_PLAIN; sc[6] = K_MACW; sc[7] = K_MACW; sc[8] = 3'd7;
    run_seq("R10,R2", 9);

    // R1: reset while the long tail runs
    do_reset();
    if_valid = 1'b1; if_cls = K_MACL; if_tag = 4'd9;
    @(posedge clk); @(negedge clk);
    if_valid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    total++;
    if (!mul_busy) begin
      bad++;
      $display("FAIL R5 tail before reset: actual busy=%b expected busy=1", mul_busy);
    end
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check_reset("mid-tail reset");
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check_reset("cycle after mid-tail reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule